// File: doc/BRIEF.md
# Microcontroller sleep sequencer

This block manages low-power states for a small 8-bit processor core. Software writes a small control register that holds a sleep-enable flag, a three-bit mode code and a request to switch off supply monitoring. The core then signals a one-cycle sleep instruction. If the sleep-enable flag is set at that moment, the sequencer halts the core and drops the clock enables that the selected mode does not need. If the flag is clear, the instruction has no effect.

While the core is asleep, the sequencer watches the wake requests, which arrive already masked by their interrupt enables. Only the requests that are valid for the latched mode count. When one arrives, the sequencer brings the main oscillator back and waits a mode-dependent start-up count. It then holds the core halted for exactly four more cycles with all clocks running, and pulses `wake_o` for one cycle so the core can service the interrupt and continue after the sleep instruction. A system reset request during sleep takes a different path: after the start-up count it clears the control register and pulses `rst_vec_o` so the core fetches from its reset vector. No wake pulse is given on that path.

Top module: `pwr_sleep_seq`

## Requirements
- R1: A sleep instruction pulse while the control register's enable bit (bit 0) is 1 halts the core (`core_halt_o`=1) from the next cycle on. With the enable bit at 0 the pulse changes no output.
- R2: After reset `core_halt_o`, `wake_o` and `rst_vec_o` are 0, every clock enable and `bod_en_o` are 1, and `reg_rdata_o` reads 0.
- R3: The control register reads back as {bit 4: monitor-off request, bits 3:1: mode code, bit 0: enable}. Its value is unchanged by a sleep and interrupt wake cycle.
- R4: While asleep the enables {cpu, flash, io, adc, async, osc} are: code 000 = 001111, 001 = 000111, 010 = 000000, 011 = 000010, 110 = 000001, 111 = 000011. When the core is running, all enables are 1.
- R5: Mode codes 100 and 101 behave exactly as code 000 (enables, wake sources, delay).
- R6: `ext_irq_i` bits above 0 wake from every mode. `adc_irq_i` wakes only from codes 000 and 001. `io_irq_i` wakes only from code 000.
- R7: `ext_irq_i[0]` wakes from code 000 regardless of `ext0_level_i`. In every other mode it wakes only when `ext0_level_i` is 1.
- R8: `tmr2_irq_i` wakes from codes 000 and 001. From 011 and 111 it wakes only when `tmr2_async_i` is 1, and from 010 and 110 it never wakes.
- R9: For a valid wake request first seen in a sleeping cycle, `core_halt_o` stays 1 for D+4 more cycles, where D is 0 for codes 000/001, STBY_DLY for 110/111 and DEEP_DLY for 010/011. `wake_o` is then 1 for exactly one cycle with `core_halt_o`=0, and all clock enables return to 1.
- R10: A `sys_rst_i` pulse while asleep keeps the core halted for D cycles and then pulses `rst_vec_o` for one cycle with no `wake_o`. A pulse during the start-up count after a wake also ends in `rst_vec_o` and not `wake_o`. In any state `sys_rst_i` clears the control register.
- R11: `bod_en_o` is 0 only while asleep in code 010 or 011 with the monitor-off bit set. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 5 | Control register write data |
| reg_rdata_o | output | 5 | Control register read data |
| sleep_instr_i | input | 1 | One-cycle pulse: core executed a sleep instruction |
| sys_rst_i | input | 1 | Synchronous system reset request |
| ext_irq_i | input | NEXT | Enabled external interrupt requests |
| ext0_level_i | input | 1 | External interrupt 0 is configured level-sensitive |
| tmr2_irq_i | input | 1 | Enabled timer-2 interrupt request |
| tmr2_async_i | input | 1 | Timer 2 runs from its asynchronous clock |
| adc_irq_i | input | 1 | Enabled converter-done interrupt request |
| io_irq_i | input | 1 | Any other enabled peripheral interrupt request |
| clk_cpu_en_o | output | 1 | CPU clock enable |
| clk_flash_en_o | output | 1 | Flash clock enable |
| clk_io_en_o | output | 1 | I/O clock enable |
| clk_adc_en_o | output | 1 | Converter clock enable |
| clk_async_en_o | output | 1 | Asynchronous timer clock enable |
| osc_main_en_o | output | 1 | Main oscillator enable |
| bod_en_o | output | 1 | Supply monitor enable |
| core_halt_o | output | 1 | Core is held halted |
| wake_o | output | 1 | One-cycle pulse: service the wake interrupt |
| rst_vec_o | output | 1 | One-cycle pulse: fetch from the reset vector |

## Verification
The hardest situation to reach is a reset request that arrives in the middle of the start-up count after an interrupt has already begun the wake. It must override the pending resume without moving the end of the count. The bench reaches it by waking from a deep mode, waiting a few cycles into the count and then pulsing the reset request. It expects `rst_vec_o` at the cycle where the wake would have started its four halt cycles. A near-exhaustive sweep crosses all eight mode codes with seven wake-source patterns, including edge-configured and level-configured external interrupt 0 and synchronous and asynchronous timer 2. Each rejected source is followed by a valid wake, so every combination returns to the running state.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  localparam int unsigned CTRL_W      = 5;
  localparam int unsigned HALT_CYCLES = 4;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_STARTUP = 3'd2,
    ST_HALT4   = 3'd3,
    ST_RESUME  = 3'd4
  } pwr_state_e;

  typedef enum logic [2:0] {
    MD_IDLE      = 3'b000,
    MD_ADC_QUIET = 3'b001,
    MD_PWR_OFF   = 3'b010,
    MD_PWR_SAVE  = 3'b011,
    MD_STBY      = 3'b110,
    MD_STBY_EXT  = 3'b111
  } pwr_mode_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic async_clk;
    logic osc;
  } clk_en_t;

  // Reserved codes fall back to the lightest mode.
  function automatic pwr_mode_e decode_mode(input logic [2:0] code);
    pwr_mode_e m;
    case (code)
      3'b001:  m = MD_ADC_QUIET;
      3'b010:  m = MD_PWR_OFF;
      3'b011:  m = MD_PWR_SAVE;
      3'b110:  m = MD_STBY;
      3'b111:  m = MD_STBY_EXT;
      default: m = MD_IDLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned NEXT = 3
) (
  input  pwr_mode_e       mode_i,
  input  logic [NEXT-1:0] ext_irq_i,
  input  logic            ext0_level_i,
  input  logic            tmr2_irq_i,
  input  logic            tmr2_async_i,
  input  logic            adc_irq_i,
  input  logic            io_irq_i,
  output logic            wake_ok_o
);
  logic is_idle, is_adcq, async_keep;
  logic ext0_ok, ext_hi_ok, tmr2_ok, adc_ok, io_ok;

  always_comb begin
    is_idle    = (mode_i == MD_IDLE);
    is_adcq    = (mode_i == MD_ADC_QUIET);
    async_keep = (mode_i == MD_PWR_SAVE) || (mode_i == MD_STBY_EXT);
    ext0_ok    = ext_irq_i[0] && (is_idle || ext0_level_i);
    tmr2_ok    = tmr2_irq_i && (is_idle || is_adcq || (async_keep && tmr2_async_i));
    adc_ok     = adc_irq_i && (is_idle || is_adcq);
    io_ok      = io_irq_i && is_idle;
  end

  generate
    if (NEXT > 1) begin : g_ext_hi
      assign ext_hi_ok = |ext_irq_i[NEXT-1:1];
    end else begin : g_ext_none
      assign ext_hi_ok = 1'b0;
    end
  endgenerate

  assign wake_ok_o = ext0_ok | ext_hi_ok | tmr2_ok | adc_ok | io_ok;
endmodule

// File: rtl/pwr_clk_sel.sv
module pwr_clk_sel
  import pwr_sleep_pkg::*;
(
  input  pwr_state_e state_i,
  input  pwr_mode_e  mode_i,
  input  logic       bod_off_i,
  output clk_en_t    clk_en_o,
  output logic       bod_en_o
);
  clk_en_t sleep_cfg;

  always_comb begin
    sleep_cfg = '0;
    unique case (mode_i)
      MD_IDLE:      sleep_cfg = '{cpu:1'b0, flash:1'b0, io:1'b1, adc:1'b1, async_clk:1'b1, osc:1'b1};
      MD_ADC_QUIET: sleep_cfg = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b1, async_clk:1'b1, osc:1'b1};
      MD_PWR_OFF:   sleep_cfg = '0;
      MD_PWR_SAVE:  sleep_cfg = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b0, async_clk:1'b1, osc:1'b0};
      MD_STBY:      sleep_cfg = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b0, async_clk:1'b0, osc:1'b1};
      MD_STBY_EXT:  sleep_cfg = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b0, async_clk:1'b1, osc:1'b1};
      default:      sleep_cfg = '0;
    endcase
  end

  always_comb begin
    clk_en_o = '1;
    if (state_i == ST_SLEEP) begin
      clk_en_o = sleep_cfg;
    end else if (state_i == ST_STARTUP) begin
      clk_en_o     = sleep_cfg;
      clk_en_o.osc = 1'b1;
    end
  end

  assign bod_en_o = !((state_i == ST_SLEEP) && bod_off_i &&
                      ((mode_i == MD_PWR_OFF) || (mode_i == MD_PWR_SAVE)));
endmodule

// File: rtl/pwr_dly_cnt.sv
module pwr_dly_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (dec_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned NEXT     = 3,
  parameter int unsigned STBY_DLY = 6,
  parameter int unsigned DEEP_DLY = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  input  logic              sleep_instr_i,
  input  logic              sys_rst_i,
  input  logic [NEXT-1:0]   ext_irq_i,
  input  logic              ext0_level_i,
  input  logic              tmr2_irq_i,
  input  logic              tmr2_async_i,
  input  logic              adc_irq_i,
  input  logic              io_irq_i,
  output logic              clk_cpu_en_o,
  output logic              clk_flash_en_o,
  output logic              clk_io_en_o,
  output logic              clk_adc_en_o,
  output logic              clk_async_en_o,
  output logic              osc_main_en_o,
  output logic              bod_en_o,
  output logic              core_halt_o,
  output logic              wake_o,
  output logic              rst_vec_o
);
  localparam int unsigned MAX_A = (STBY_DLY > DEEP_DLY) ? STBY_DLY : DEEP_DLY;
  localparam int unsigned MAX_D = (MAX_A > HALT_CYCLES) ? MAX_A : HALT_CYCLES;
  localparam int unsigned CW    = $clog2(MAX_D + 1);
  localparam logic [CW-1:0] HALT_M1 = CW'(HALT_CYCLES - 1);

  logic rst_sync_n;

  // control register fields
  logic       se_q, bod_off_q;
  logic [2:0] mode_code_q;
  pwr_mode_e  mode_q;

  pwr_state_e state_q, state_d;
  logic       rflag_q, rflag_d;
  logic       rst_vec_q, rst_pulse_d;
  logic       capture;
  logic       cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0] cnt_load_val, mode_dly;
  logic       wake_ok;
  clk_en_t    clk_en;

  pwr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  pwr_wake_qual #(.NEXT(NEXT)) u_wake_qual (
    .mode_i      (mode_q),
    .ext_irq_i   (ext_irq_i),
    .ext0_level_i(ext0_level_i),
    .tmr2_irq_i  (tmr2_irq_i),
    .tmr2_async_i(tmr2_async_i),
    .adc_irq_i   (adc_irq_i),
    .io_irq_i    (io_irq_i),
    .wake_ok_o   (wake_ok)
  );

  pwr_clk_sel u_clk_sel (
    .state_i  (state_q),
    .mode_i   (mode_q),
    .bod_off_i(bod_off_q),
    .clk_en_o (clk_en),
    .bod_en_o (bod_en_o)
  );

  pwr_dly_cnt #(.CW(CW)) u_dly_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .load_i    (cnt_load),
    .load_val_i(cnt_load_val),
    .dec_i     (cnt_dec),
    .zero_o    (cnt_zero)
  );

  // start-up length for the latched mode
  always_comb begin
    unique case (mode_q)
      MD_STBY, MD_STBY_EXT:    mode_dly = CW'(STBY_DLY);
      MD_PWR_OFF, MD_PWR_SAVE: mode_dly = CW'(DEEP_DLY);
      default:                 mode_dly = '0;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d      = state_q;
    rflag_d      = rflag_q;
    rst_pulse_d  = 1'b0;
    capture      = 1'b0;
    cnt_load     = 1'b0;
    cnt_load_val = mode_dly - 1'b1;
    cnt_dec      = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        rflag_d = 1'b0;
        if (sys_rst_i) begin
          rst_pulse_d = 1'b1;
        end else if (sleep_instr_i && se_q) begin
          state_d = ST_SLEEP;
          capture = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (sys_rst_i || wake_ok) begin
          if (mode_dly == '0) begin
            if (sys_rst_i) begin
              state_d     = ST_ACTIVE;
              rst_pulse_d = 1'b1;
            end else begin
              state_d      = ST_HALT4;
              cnt_load     = 1'b1;
              cnt_load_val = HALT_M1;
            end
          end else begin
            state_d  = ST_STARTUP;
            cnt_load = 1'b1;
            rflag_d  = sys_rst_i;
          end
        end
      end
      ST_STARTUP: begin
        if (sys_rst_i) rflag_d = 1'b1;
        if (cnt_zero) begin
          if (rflag_q || sys_rst_i) begin
            state_d     = ST_ACTIVE;
            rst_pulse_d = 1'b1;
            rflag_d     = 1'b0;
          end else begin
            state_d      = ST_HALT4;
            cnt_load     = 1'b1;
            cnt_load_val = HALT_M1;
          end
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_HALT4: begin
        if (sys_rst_i) begin
          state_d     = ST_ACTIVE;
          rst_pulse_d = 1'b1;
        end else if (cnt_zero) begin
          state_d = ST_RESUME;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_RESUME: begin
        state_d     = ST_ACTIVE;
        rst_pulse_d = sys_rst_i;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  // sequencer registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_ACTIVE;
      rflag_q   <= 1'b0;
      rst_vec_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rflag_q   <= rflag_d;
      rst_vec_q <= rst_pulse_d;
    end
  end

  // control register
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      se_q        <= 1'b0;
      mode_code_q <= 3'b000;
      bod_off_q   <= 1'b0;
    end else if (sys_rst_i) begin
      se_q        <= 1'b0;
      mode_code_q <= 3'b000;
      bod_off_q   <= 1'b0;
    end else if (reg_we_i) begin
      se_q        <= reg_wdata_i[0];
      mode_code_q <= reg_wdata_i[3:1];
      bod_off_q   <= reg_wdata_i[4];
    end
  end

  // mode latched at the sleep instruction
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= MD_IDLE;
    else if (capture) mode_q <= decode_mode(mode_code_q);
  end

  assign reg_rdata_o    = {bod_off_q, mode_code_q, se_q};
  assign clk_cpu_en_o   = clk_en.cpu;
  assign clk_flash_en_o = clk_en.flash;
  assign clk_io_en_o    = clk_en.io;
  assign clk_adc_en_o   = clk_en.adc;
  assign clk_async_en_o = clk_en.async_clk;
  assign osc_main_en_o  = clk_en.osc;
  assign core_halt_o    = (state_q != ST_ACTIVE) && (state_q != ST_RESUME);
  assign wake_o         = (state_q == ST_RESUME);
  assign rst_vec_o      = rst_vec_q;
endmodule

// File: rtl/pwr_sleep_seq_chk.sv
module pwr_sleep_seq_chk
  import pwr_sleep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_n,
  input pwr_state_e state_i,
  input logic       se_i,
  input logic       sleep_instr_i,
  input logic       core_halt_o,
  input logic       wake_o,
  input logic       rst_vec_o,
  input logic       clk_cpu_en_o,
  input logic       clk_flash_en_o,
  input logic       clk_io_en_o,
  input logic       clk_adc_en_o,
  input logic       clk_async_en_o,
  input logic       osc_main_en_o,
  input logic       bod_en_o
);
  a_r1_no_entry_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_i == ST_ACTIVE && sleep_instr_i && !se_i) |=> !core_halt_o);

  a_r4_running_clocks_on: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_i == ST_ACTIVE) |-> (clk_cpu_en_o && clk_flash_en_o && clk_io_en_o &&
                                clk_adc_en_o && clk_async_en_o && osc_main_en_o));

  a_r4_asleep_cpu_off: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_i == ST_SLEEP) |-> (!clk_cpu_en_o && !clk_flash_en_o));

  a_r9_wake_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_o |=> !wake_o);

  a_r9_resume_after_halt: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_o |-> ($past(state_i) == ST_HALT4));

  a_r10_reset_no_wake: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_vec_o |-> (!wake_o && !core_halt_o));

  a_r11_bod_off_only_asleep: assert property (@(posedge clk_i) disable iff (!rst_n)
    !bod_en_o |-> (state_i == ST_SLEEP));
endmodule

bind pwr_sleep_seq pwr_sleep_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_sync_n),
  .state_i       (state_q),
  .se_i          (se_q),
  .sleep_instr_i (sleep_instr_i),
  .core_halt_o   (core_halt_o),
  .wake_o        (wake_o),
  .rst_vec_o     (rst_vec_o),
  .clk_cpu_en_o  (clk_cpu_en_o),
  .clk_flash_en_o(clk_flash_en_o),
  .clk_io_en_o   (clk_io_en_o),
  .clk_adc_en_o  (clk_adc_en_o),
  .clk_async_en_o(clk_async_en_o),
  .osc_main_en_o (osc_main_en_o),
  .bod_en_o      (bod_en_o)
);

// File: tb/pwr_sleep_seq_tb.sv
module pwr_sleep_seq_tb;
  localparam int NEXT = 2;
  localparam int SD   = 6;
  localparam int DD   = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            reg_we;
  logic [4:0]      reg_wdata;
  logic [4:0]      reg_rdata;
  logic            sleep_instr, sys_rst;
  logic [NEXT-1:0] ext_irq;
  logic            ext0_level, tmr2_irq, tmr2_async, adc_irq, io_irq;
  logic            c_cpu, c_flash, c_io, c_adc, c_async, c_osc;
  logic            bod_en, core_halt, wake, rst_vec;

  int checks = 0;
  int fails  = 0;

  pwr_sleep_seq #(.NEXT(NEXT), .STBY_DLY(SD), .DEEP_DLY(DD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sleep_instr_i(sleep_instr), .sys_rst_i(sys_rst),
    .ext_irq_i(ext_irq), .ext0_level_i(ext0_level),
    .tmr2_irq_i(tmr2_irq), .tmr2_async_i(tmr2_async),
    .adc_irq_i(adc_irq), .io_irq_i(io_irq),
    .clk_cpu_en_o(c_cpu), .clk_flash_en_o(c_flash), .clk_io_en_o(c_io),
    .clk_adc_en_o(c_adc), .clk_async_en_o(c_async), .osc_main_en_o(c_osc),
    .bod_en_o(bod_en), .core_halt_o(core_halt), .wake_o(wake), .rst_vec_o(rst_vec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] clks();
    return {c_cpu, c_flash, c_io, c_adc, c_async, c_osc};
  endfunction

  function automatic int eff(input int code);
    return (code == 4 || code == 5) ? 0 : code;
  endfunction

  function automatic int exp_dly(input int code);
    case (eff(code))
      2, 3:    return DD;
      6, 7:    return SD;
      default: return 0;
    endcase
  endfunction

  function automatic logic [5:0] exp_clk(input int code);
    case (eff(code))
      0:       return 6'b001111;
      1:       return 6'b000111;
      3:       return 6'b000010;
      6:       return 6'b000001;
      7:       return 6'b000011;
      default: return 6'b000000;
    endcase
  endfunction

  // src: 0 ext0 edge, 1 ext0 level, 2 ext1, 3 tmr2 sync, 4 tmr2 async, 5 adc, 6 io
  function automatic bit exp_wake(input int code, input int src);
    int m = eff(code);
    case (src)
      0:       return m == 0;
      1, 2:    return 1'b1;
      3, 5:    return m == 0 || m == 1;
      4:       return m == 0 || m == 1 || m == 3 || m == 7;
      default: return m == 0;
    endcase
  endfunction

  function automatic string src_req(input int src);
    case (src)
      0, 1:    return "R7";
      3, 4:    return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic set_src(input int src, input bit v);
    case (src)
      0: begin ext0_level = 1'b0; ext_irq[0] = v; end
      1: begin ext0_level = v;    ext_irq[0] = v; end
      2: ext_irq[1] = v;
      3: begin tmr2_async = 1'b0; tmr2_irq = v; end
      4: begin tmr2_async = v;    tmr2_irq = v; end
      5: adc_irq = v;
      default: io_irq = v;
    endcase
  endtask

  task automatic write_reg(input logic [4:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic enter_sleep(input int code, input bit bod);
    string rq;
    write_reg({bod, 3'(code), 1'b1});
    sleep_instr = 1'b1;
    @(negedge clk);
    sleep_instr = 1'b0;
    rq = (code == 4 || code == 5) ? "R5" : "R4";
    chk(core_halt == 1'b1, "R1 halt on entry", int'(core_halt), 1);
    chk(clks() == exp_clk(code), rq, int'(clks()), int'(exp_clk(code)));
    chk(bod_en == !(bod && (code == 2 || code == 3)), "R11",
        int'(bod_en), int'(!(bod && (code == 2 || code == 3))));
  endtask

  // source already applied at the current negedge
  task automatic expect_wake(input int code, input string req);
    int d = exp_dly(code);
    bit ok = 1'b1;
    for (int k = 1; k <= d + 5; k++) begin
      @(negedge clk);
      if (k < d + 5 && (!core_halt || wake)) ok = 1'b0;
    end
    chk(ok && wake && !core_halt, $sformatf("%s R9 code=%0d", req, code), int'({ok, wake, core_halt}), 3'b110);
    @(negedge clk);
    chk(!wake && clks() == 6'h3f, "R9 after resume", int'({wake, clks()}), 7'h3f);
  endtask

  task automatic expect_rst(input int d, input string req);
    bit ok = 1'b1;
    for (int k = 1; k <= d + 1; k++) begin
      @(negedge clk);
      if (k == 1) sys_rst = 1'b0;
      if (k < d + 1 && (!core_halt || rst_vec || wake)) ok = 1'b0;
    end
    chk(ok && rst_vec && !core_halt && !wake, req, int'({ok, rst_vec, core_halt, wake}), 4'b1100);
    chk(reg_rdata == 5'h00, "R10 register cleared", int'(reg_rdata), 0);
    @(negedge clk);
    chk(!rst_vec && !wake, "R10 single pulse", int'({rst_vec, wake}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; sleep_instr = 1'b0; sys_rst = 1'b0;
    ext_irq = '0; ext0_level = 1'b0; tmr2_irq = 1'b0; tmr2_async = 1'b0;
    adc_irq = 1'b0; io_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk(!core_halt && !wake && !rst_vec, "R2 status", int'({core_halt, wake, rst_vec}), 0);
    chk(clks() == 6'h3f && bod_en, "R2 clocks", int'({clks(), bod_en}), 7'h7f);
    chk(reg_rdata == 5'h00, "R2 register", int'(reg_rdata), 0);

    // R1 disabled sleep is a no-op; R3 field layout
    write_reg(5'b00100);
    chk(reg_rdata == 5'h04, "R3 readback", int'(reg_rdata), 4);
    sleep_instr = 1'b1;
    @(negedge clk);
    sleep_instr = 1'b0;
    begin
      bit ok = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (core_halt || clks() != 6'h3f || !bod_en) ok = 1'b0;
        @(negedge clk);
      end
      chk(ok, "R1 no-op without enable", int'(core_halt), 0);
    end

    // sweep of modes and wake sources
    for (int code = 0; code < 8; code++) begin
      for (int src = 0; src < 7; src++) begin
        bit bod = src[0];
        enter_sleep(code, bod);
        set_src(src, 1'b1);
        if (exp_wake(code, src)) begin
          expect_wake(code, src_req(src));
          set_src(src, 1'b0);
        end else begin
          bit ok = 1'b1;
          for (int k = 0; k < DD + 10; k++) begin
            @(negedge clk);
            if (!core_halt || wake) ok = 1'b0;
          end
          chk(ok, $sformatf("%s ignored code=%0d src=%0d", src_req(src), code, src), int'(wake), 0);
          set_src(src, 1'b0);
          set_src(2, 1'b1);
          expect_wake(code, "R6");
          set_src(2, 1'b0);
        end
        chk(reg_rdata == {bod, 3'(code), 1'b1}, "R3 kept over sleep",
            int'(reg_rdata), int'({bod, 3'(code), 1'b1}));
      end
    end

    // R10 reset during sleep in several modes
    enter_sleep(2, 1'b0);
    sys_rst = 1'b1;
    expect_rst(DD, "R10 deep");
    enter_sleep(6, 1'b0);
    sys_rst = 1'b1;
    expect_rst(SD, "R10 standby");
    enter_sleep(0, 1'b0);
    sys_rst = 1'b1;
    expect_rst(0, "R10 idle");

    // R10 reset arriving during start-up after an interrupt wake
    enter_sleep(3, 1'b0);
    set_src(2, 1'b1);
    begin
      bit ok = 1'b1;
      for (int k = 1; k <= DD + 1; k++) begin
        @(negedge clk);
        if (k == 1) set_src(2, 1'b0);
        if (k == 3) sys_rst = 1'b1;
        if (k == 4) sys_rst = 1'b0;
        if (k < DD + 1 && (!core_halt || wake || rst_vec)) ok = 1'b0;
      end
      chk(ok && rst_vec && !wake, "R10 during start-up", int'({ok, rst_vec, wake}), 3'b110);
      @(negedge clk);
      chk(!wake && !rst_vec, "R10 no late wake", int'({wake, rst_vec}), 0);
    end

    // R1 after reset path the enable is clear, so sleep is a no-op
    sleep_instr = 1'b1;
    @(negedge clk);
    sleep_instr = 1'b0;
    @(negedge clk);
    chk(!core_halt, "R1 cleared enable", int'(core_halt), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule